// File: doc/BRIEF.md
# Quadrature Position Counter with Compare-Clear

This block turns a two-phase incremental encoder signal into a 16-bit position count. Both phases pass through a synchronizer. Every valid Gray-code transition then moves the counter by one step, which gives 4x resolution. When phase A leads, the counter counts up. When phase B leads, it counts down. On a rising edge of the run enable, the counter is loaded from a programmable start register. While the block runs, each count event compares the counter against two compare registers. A match raises a one-cycle interrupt pulse for that channel. It can also force the counter to zero, under a separate enable for each channel.

A down step taken from zero is an underflow. An underflow raises a one-cycle flag. The counter then either wraps to FFFFH or reloads from compare register 0, depending on the reload enable. The reload always takes the compare value that is current before the edge, so a software write landing on the same edge can never corrupt it. Software programs the block through a simple write port. Control, comparison and status pins are all plain, with no handshake.

Top module: `qenc_cmp_counter`

## Requirements
- R1: Phases are synchronized through two flops. Transitions 00→10→11→01→00 (written {A,B}) count up, and the reverse order counts down. A change in both phases at once is ignored.
- R2: When run_en rises, the counter loads the start register (address 3). No step is taken in that cycle.
- R3: The counter counts only while run_en stays high and the control mode field (address 0, bits 3:0) is 1000b (compare) or 1010b (capture-compare). Otherwise it holds its value.
- R4: At each count event, the counter value before the step is compared with compare register 0 (address 1) and compare register 1 (address 2). A match pulses match0_irq or match1_irq for one cycle, in the same cycle that the count output updates.
- R5: Control bit 4 arms clear-on-match for channel 0, and bit 5 arms it for channel 1. An armed match sets the counter to 0000H instead of stepping, and this overrides an underflow.
- R6: A compare register equal to the start value matches, and clears if armed, on the very first count event after start.
- R7: A down step from 0000H pulses underflow_flag for one cycle. With reload disabled, the counter wraps to FFFFH.
- R8: With control bit 6 set, an underflow reloads the counter from compare register 0.
- R9: When a write to compare register 0 lands on the same edge as an underflow reload, the reload uses the old value. The new value applies to later reloads.
- R10: In capture-compare mode, channel 1 never matches and never clears the counter.
- R11: After reset, the count is 0000H, all pulses are low, and all registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| run_en | input | 1 | Count enable; its rising edge loads the start value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare 0, 2 compare 1, 3 start value |
| wr_data | input | 16 | Write data |
| count | output | 16 | Counter value |
| match0_irq | output | 1 | Channel 0 match pulse |
| match1_irq | output | 1 | Channel 1 match pulse |
| underflow_flag | output | 1 | Underflow pulse |

## Verification
The assertions check the following on every cycle:
- Up and down steps never occur together.
- A start loads the start value.
- An armed match leaves the counter at zero.
- An underflow lands on FFFFH or on the previous compare 0 value, depending on the reload bit.
- The counter holds while it is not running.
- Channel 1 stays silent in capture-compare mode.

Only the bench scenarios can show the remaining behaviour. These cover the actual direction sequence from the pins through the synchronizer, a match on the first count when a compare value equals the start value, and a compare write that collides with an underflow on the same edge. They also show that the newly written value governs the next underflow.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  localparam logic [3:0] MODE_ENC_CMP = 4'b1000;
  localparam logic [3:0] MODE_ENC_CAP = 4'b1010;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_CMP0  = 2'd1,
    A_CMP1  = 2'd2,
    A_START = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       reload_en;
    logic       clr1_en;
    logic       clr0_en;
    logic [3:0] mode;
  } ctrl_t;
endpackage

// File: rtl/qenc_phase_decode.sv
module qenc_phase_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_a,
  input  logic phase_b,
  output logic step_up,
  output logic step_dn
);
  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic a_prev, b_prev;
  logic a_cur, b_cur;

  // Synchronizer chain, depth set by parameter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], phase_a};
      b_sync <= {b_sync[SYNC_STAGES-2:0], phase_b};
      a_prev <= a_cur;
      b_prev <= b_cur;
    end
  end

  assign a_cur = a_sync[SYNC_STAGES-1];
  assign b_cur = b_sync[SYNC_STAGES-1];

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    case ({a_prev, b_prev, a_cur, b_cur})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: step_up = 1'b1;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: step_dn = 1'b1;
      default: ;
    endcase
  end

  p_step_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output ctrl_t             ctrl,
  output logic [W-1:0]      cmp0,
  output logic [W-1:0]      cmp1,
  output logic [W-1:0]      start_val
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cmp0      <= '0;
      cmp1      <= '0;
      start_val <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CTRL:  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_CMP0:  cmp0      <= wr_data;
        A_CMP1:  cmp1      <= wr_data;
        A_START: start_val <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         start_pulse,
  input  logic         run_active,
  input  logic         ch1_cmp_en,
  input  logic         clr0_en,
  input  logic         clr1_en,
  input  logic         reload_en,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  input  logic [W-1:0] start_val,
  output logic [W-1:0] count,
  output logic         match0,
  output logic         match1,
  output logic         underflow
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic         evt, hit0, hit1, do_clr, do_under;
  logic [W-1:0] nxt;

  always_comb begin
    evt      = run_active && (step_up || step_dn);
    hit0     = evt && (count == cmp0);
    hit1     = evt && ch1_cmp_en && (count == cmp1);
    do_clr   = (hit0 && clr0_en) || (hit1 && clr1_en);
    do_under = evt && step_dn && !do_clr && (count == '0);
    if (!evt)          nxt = count;
    else if (do_clr)   nxt = '0;
    else if (do_under) nxt = reload_en ? cmp0 : ALL_ONES;  // cmp0 is pre-edge value
    else if (step_up)  nxt = count + 1'b1;
    else               nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      match0    <= 1'b0;
      match1    <= 1'b0;
      underflow <= 1'b0;
    end else if (start_pulse) begin
      count     <= start_val;
      match0    <= 1'b0;
      match1    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      count     <= nxt;
      match0    <= hit0;
      match1    <= hit1;
      underflow <= do_under;
    end
  end

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_pulse) && $past(rst_n) |-> count == $past(start_val));
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(run_active) && !$past(start_pulse) |-> count == $past(count));
  p_clear0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match0 && $past(clr0_en) |-> count == '0);
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !$past(reload_en) |-> count == ALL_ONES);
  p_reload_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && $past(reload_en) |-> count == $past(cmp0));
  p_ch1_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    match1 |-> $past(ch1_cmp_en));
endmodule

// File: rtl/qenc_cmp_counter.sv
module qenc_cmp_counter
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              match0_irq,
  output logic              match1_irq,
  output logic              underflow_flag
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp0, cmp1, start_val;
  logic             step_up, step_dn;
  logic             run_q, start_pulse, mode_ok, run_active;

  qenc_phase_decode #(.SYNC_STAGES(2)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .step_up(step_up), .step_dn(step_dn)
  );

  qenc_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .cmp0(cmp0), .cmp1(cmp1),
    .start_val(start_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  assign start_pulse = run_en && !run_q;
  assign mode_ok     = (ctrl.mode == MODE_ENC_CMP) || (ctrl.mode == MODE_ENC_CAP);
  assign run_active  = run_en && run_q && mode_ok;

  qenc_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .start_pulse(start_pulse), .run_active(run_active),
    .ch1_cmp_en(ctrl.mode == MODE_ENC_CMP),
    .clr0_en(ctrl.clr0_en), .clr1_en(ctrl.clr1_en), .reload_en(ctrl.reload_en),
    .cmp0(cmp0), .cmp1(cmp1), .start_val(start_val),
    .count(count), .match0(match0_irq), .match1(match1_irq),
    .underflow(underflow_flag)
  );

  p_reset_r11: assert property (@(posedge clk)
    !$past(rst_n) && $past(rst_n, 2) |-> count == '0 && !match0_irq && !underflow_flag);
endmodule

// File: tb/qenc_cmp_counter_tb_top.sv
`timescale 1ns/1ps
module qenc_cmp_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, run_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        match0_irq, match1_irq, underflow_flag;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qenc_cmp_counter dut_i (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .run_en(run_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .match0_irq(match0_irq), .match1_irq(match1_irq),
    .underflow_flag(underflow_flag)
  );

  // {dir(1=up), count, m0, m1, uf}; setup start=3, cmp0=5 armed, cmp1=2
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 16'h0004, 3'b000}, {1'b1, 16'h0005, 3'b000},
    {1'b1, 16'h0000, 3'b100}, {1'b0, 16'hFFFF, 3'b001},
    {1'b1, 16'h0000, 3'b000}, {1'b1, 16'h0001, 3'b000},
    {1'b1, 16'h0002, 3'b000}, {1'b1, 16'h0003, 3'b010},
    {1'b0, 16'h0002, 3'b000}, {1'b0, 16'h0001, 3'b010}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic move(input bit up);
    if (up) begin if (phase_a == phase_b) phase_a = ~phase_a; else phase_b = ~phase_b; end
    else    begin if (phase_a == phase_b) phase_b = ~phase_b; else phase_a = ~phase_a; end
  endtask

  // step; optional compare-0 write landing on the counter update edge
  task automatic step(input bit up, input bit do_wr, input logic [15:0] wd);
    @(negedge clk); move(up);
    @(negedge clk);
    @(negedge clk);
    if (do_wr) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = wd; end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 count", count, 16'h0000);
    chk("R11 pulses", {13'd0, match0_irq, match1_irq, underflow_flag}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd0, 16'h0018); wr(2'd1, 16'h0005); wr(2'd2, 16'h0002); wr(2'd3, 16'h0003);
    restart();
    chk("R2 start load", count, 16'h0003);
    for (int i = 0; i < 10; i++) begin
      step(VEC[i][19], 1'b0, 16'h0);
      chk($sformatf("R1/R4/R5/R7 vec%0d count", i), count, VEC[i][18:3]);
      chk($sformatf("R4/R7 vec%0d pulses", i),
          {13'd0, match0_irq, match1_irq, underflow_flag}, {13'd0, VEC[i][2:0]});
    end

    // R6: compare equals start value, first count clears
    wr(2'd3, 16'h0007); wr(2'd1, 16'h0007);
    restart();
    step(1'b1, 1'b0, 16'h0);
    chk("R6 first-count clear", count, 16'h0000);
    chk("R6 first-count irq", {15'd0, match0_irq}, 16'h1);

    // R8: reload from compare 0
    wr(2'd0, 16'h0048); wr(2'd1, 16'h0040); wr(2'd3, 16'h0000);
    restart();
    step(1'b0, 1'b0, 16'h0);
    chk("R8 reload value", count, 16'h0040);
    chk("R8 underflow flag", {15'd0, underflow_flag}, 16'h1);

    // R9: colliding write uses old value, new one applies next
    restart();
    step(1'b0, 1'b1, 16'h0099);
    chk("R9 old value on collision", count, 16'h0040);
    restart();
    step(1'b0, 1'b0, 16'h0);
    chk("R9 new value afterwards", count, 16'h0099);

    // R10: capture-compare mode ignores channel 1
    wr(2'd0, 16'h002A); wr(2'd1, 16'h1234); wr(2'd2, 16'h0010); wr(2'd3, 16'h0010);
    restart();
    step(1'b1, 1'b0, 16'h0);
    chk("R10 no clear", count, 16'h0011);
    chk("R10 no irq", {15'd0, match1_irq}, 16'h0);
    wr(2'd0, 16'h0028);
    restart();
    step(1'b1, 1'b0, 16'h0);
    chk("R5 ch1 clear in compare mode", count, 16'h0000);
    chk("R5 ch1 irq", {15'd0, match1_irq}, 16'h1);

    // R3: other mode and run_en low hold the counter
    wr(2'd0, 16'h0003);
    restart();
    step(1'b1, 1'b0, 16'h0);
    chk("R3 bad mode holds", count, 16'h0010);
    wr(2'd0, 16'h0008);
    @(negedge clk); run_en = 1'b0;
    step(1'b1, 1'b0, 16'h0);
    chk("R3 run_en low holds", count, 16'h0010);

    // R1: simultaneous change of both phases is ignored
    restart();
    @(negedge clk); phase_a = ~phase_a; phase_b = ~phase_b;
    repeat (4) @(negedge clk);
    chk("R1 double change ignored", count, 16'h0010);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule